// File: doc/BRIEF.md
# Edge Mirror Select Generator

This block drives the per-tap source selects of the reflection multiplexer that sits in front of a five-tap (generally 2·HALF+1 tap) filter. When the filter works on the first or last lines of a window that touches the image edge, taps that reach outside the image would have no data. The block then points those taps at the matching lines on the inner side of the edge, so the filter sees a mirrored neighbourhood. The same block serves horizontal filtering (pixel positions along a row) and vertical filtering (lines along a column).

A position counter tracks the output line being produced. It is cleared by a start-of-window pulse and stepped by the advance pulse from the output line counter. Software enables mirroring at the start edge and at the end edge separately, depending on whether each edge of the window is also an image edge. A programmable last-line value marks the final position of the window, and end mirroring is measured from it. The selects are registered and hold the source index for each tap.

Top module: `mirror_edge_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the position returns to 0 and every tap select takes its normal source. Select field k sits at bits [3k+2:3k]; tap 0 is the n-2 tap and tap 4 the n+2 tap. A code v means source line n+(v-2), so the normal (identity) code of tap k is k.
- R2: `win_start` sets the position to 0, and it wins over `line_adv` asserted in the same cycle.
- R3: Each `line_adv` without `win_start` raises the position by one. At the all-ones value the position saturates and does not wrap.
- R4: With start mirroring enabled at position 0, tap 0 selects code 4 and tap 1 selects code 3. Taps 2 to 4 keep their normal codes unless R6 or R7 applies.
- R5: With start mirroring enabled at position 1, tap 0 selects code 2 (the centre line). Taps 1 to 4 keep their normal codes unless end mirroring applies.
- R6: With end mirroring enabled at a position equal to `last_line`, tap 4 selects code 0 and tap 3 selects code 1.
- R7: With end mirroring enabled at position `last_line`-1, tap 4 selects code 2. Tap 3 keeps code 3.
- R8: When an edge's enable is low, the taps on that edge's side keep their normal codes whatever the position is. With both enables low, all taps are normal.
- R9: At positions 2 or more away from both edges, and at any position beyond `last_line`, all taps are normal.
- R10: `tap_sel` is registered. It reflects the inputs sampled at the preceding clock edge and does not change between edges.
- R11: Start and end mirroring act on separate tap halves. In a window of one or two lines they apply together, and every select code stays within 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | Start-of-window pulse, clears the position |
| line_adv | input | 1 | Advance pulse from the output line counter |
| start_mirror_en | input | 1 | Enables reflection at the window start |
| end_mirror_en | input | 1 | Enables reflection at the window end |
| last_line | input | CNT_W (12) | Position of the last line in the window |
| tap_sel | output | TAPS*SEL_W (15) | Per-tap source codes, tap 0 in the low field |

## Verification
A vector table walks a full six-line window with both edges enabled, and each position shows a different select pattern: start pair, start single, plain middle, end single, end pair, and beyond the end. The same walk with enables low shows that reflection depends on the enables and not on the position alone. Windows of one and two lines show the two edges applied together, which an implementation with priority between the edges would get wrong. Directed runs cover the same-cycle clear-and-advance, the saturating counter at its all-ones limit (where a wrap would show up as identity selects), a reset taken mid-window, and the one-edge output latency.

// File: rtl/mirror_pkg.sv
package mirror_pkg;

  // number of select bits needed to address 2*half+1 delay stages
  function automatic int sel_bits(input int half);
    return $clog2(2 * half + 1);
  endfunction

  // source stage for a low-side tap reflected about position 0;
  // p is the distance of the current line from the first line
  function automatic int low_src(input int half, input int k, input int p);
    return 2 * half - 2 * p - k;
  endfunction

  // source stage for a high-side tap reflected about the last line;
  // d is the distance of the current line to the last line
  function automatic int high_src(input int half, input int k, input int d);
    return 2 * half + 2 * d - k;
  endfunction

endpackage

// File: rtl/mirror_pos_counter.sv
module mirror_pos_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] pos_next
);

  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic [CNT_W-1:0] pos_q;

  always_comb begin
    pos_next = pos_q;
    if (clr)
      pos_next = '0;
    else if (adv && (pos_q != POS_MAX))
      pos_next = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pos_q <= '0;
    else
      pos_q <= pos_next;
  end

endmodule

// File: rtl/mirror_edge_decode.sv
module mirror_edge_decode #(
  parameter int CNT_W = 12,
  parameter int HALF  = 2,
  parameter int DW    = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic [CNT_W-1:0] pos,
  input  logic             start_en,
  input  logic             end_en,
  input  logic [CNT_W-1:0] end_pos,
  output logic             lo_act,
  output logic [DW-1:0]    lo_dist,
  output logic             hi_act,
  output logic [DW-1:0]    hi_dist
);

  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

  logic [CNT_W-1:0] to_end;

  always_comb begin
    to_end  = end_pos - pos;
    lo_act  = start_en && (pos < HALF_C);
    lo_dist = pos[DW-1:0];
    hi_act  = end_en && (pos <= end_pos) && (to_end < HALF_C);
    hi_dist = to_end[DW-1:0];
  end

endmodule

// File: rtl/mirror_tap_select.sv
module mirror_tap_select
  import mirror_pkg::*;
#(
  parameter int HALF  = 2,
  parameter int DW    = (HALF > 1) ? $clog2(HALF) : 1,
  parameter int TAPS  = 2 * HALF + 1,
  parameter int SEL_W = sel_bits(HALF)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lo_act,
  input  logic [DW-1:0]         lo_dist,
  input  logic                  hi_act,
  input  logic [DW-1:0]         hi_dist,
  output logic [TAPS*SEL_W-1:0] sel_q
);

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam int OFF = k - HALF;
    logic [SEL_W-1:0] idx;

    always_comb begin
      idx = SEL_W'(k);
      if ((OFF < 0) && lo_act && ((int'(lo_dist) + OFF) < 0))
        idx = SEL_W'(low_src(HALF, k, int'(lo_dist)));
      if ((OFF > 0) && hi_act && (OFF > int'(hi_dist)))
        idx = SEL_W'(high_src(HALF, k, int'(hi_dist)));
    end

    always_ff @(posedge clk) begin
      if (rst)
        sel_q[k*SEL_W +: SEL_W] <= SEL_W'(k);
      else
        sel_q[k*SEL_W +: SEL_W] <= idx;
    end
  end

endmodule

// File: rtl/mirror_edge_ctrl.sv
module mirror_edge_ctrl
  import mirror_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int HALF  = 2,
  parameter int TAPS  = 2 * HALF + 1,
  parameter int SEL_W = sel_bits(HALF)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  win_start,
  input  logic                  line_adv,
  input  logic                  start_mirror_en,
  input  logic                  end_mirror_en,
  input  logic [CNT_W-1:0]      last_line,
  output logic [TAPS*SEL_W-1:0] tap_sel
);

  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] pos_next;
  logic             lo_act;
  logic             hi_act;
  logic [DW-1:0]    lo_dist;
  logic [DW-1:0]    hi_dist;

  mirror_pos_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (win_start),
    .adv      (line_adv),
    .pos_next (pos_next)
  );

  mirror_edge_decode #(
    .CNT_W (CNT_W),
    .HALF  (HALF),
    .DW    (DW)
  ) u_dec (
    .pos      (pos_next),
    .start_en (start_mirror_en),
    .end_en   (end_mirror_en),
    .end_pos  (last_line),
    .lo_act   (lo_act),
    .lo_dist  (lo_dist),
    .hi_act   (hi_act),
    .hi_dist  (hi_dist)
  );

  mirror_tap_select #(
    .HALF  (HALF),
    .DW    (DW),
    .TAPS  (TAPS),
    .SEL_W (SEL_W)
  ) u_sel (
    .clk     (clk),
    .rst     (rst),
    .lo_act  (lo_act),
    .lo_dist (lo_dist),
    .hi_act  (hi_act),
    .hi_dist (hi_dist),
    .sel_q   (tap_sel)
  );

endmodule

// File: rtl/mirror_edge_ctrl_chk.sv
module mirror_edge_ctrl_chk #(
  parameter int CNT_W = 12,
  parameter int HALF  = 2,
  parameter int TAPS  = 2 * HALF + 1,
  parameter int SEL_W = $clog2(2 * HALF + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  win_start,
  input logic                  line_adv,
  input logic                  start_mirror_en,
  input logic                  end_mirror_en,
  input logic [CNT_W-1:0]      last_line,
  input logic [TAPS*SEL_W-1:0] tap_sel
);

  logic [TAPS*SEL_W-1:0] ident;
  always_comb begin
    for (int k = 0; k < TAPS; k++)
      ident[k*SEL_W +: SEL_W] = SEL_W'(k);
  end

  AST_IDLE_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (!start_mirror_en && !end_mirror_en) |=> (tap_sel == ident)); // R8

  for (genvar k = 0; k < TAPS; k++) begin : g_chk
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (int'(tap_sel[k*SEL_W +: SEL_W]) <= 2 * HALF)); // R11

    if (k < HALF) begin : g_lo
      AST_START_REFLECT: assert property (@(posedge clk) disable iff (rst)
        (win_start && start_mirror_en)
        |=> (tap_sel[k*SEL_W +: SEL_W] == SEL_W'(2 * HALF - k))); // R4
      AST_START_OFF: assert property (@(posedge clk) disable iff (rst)
        (win_start && !start_mirror_en)
        |=> (tap_sel[k*SEL_W +: SEL_W] == SEL_W'(k))); // R8
    end

    if (k > HALF) begin : g_hi
      AST_END_REFLECT: assert property (@(posedge clk) disable iff (rst)
        (win_start && end_mirror_en && (last_line == '0))
        |=> (tap_sel[k*SEL_W +: SEL_W] == SEL_W'(2 * HALF - k))); // R6
    end
  end

  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!win_start && !line_adv && !start_mirror_en && !end_mirror_en)
    |=> $stable(tap_sel) || (tap_sel == ident)); // R10

endmodule

bind mirror_edge_ctrl mirror_edge_ctrl_chk #(
  .CNT_W (CNT_W),
  .HALF  (HALF),
  .TAPS  (TAPS),
  .SEL_W (SEL_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .win_start       (win_start),
  .line_adv        (line_adv),
  .start_mirror_en (start_mirror_en),
  .end_mirror_en   (end_mirror_en),
  .last_line       (last_line),
  .tap_sel         (tap_sel)
);

// File: tb/mirror_edge_ctrl_test.sv
module mirror_edge_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;

  localparam logic [14:0] ID  = {3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [14:0] S0  = {3'd4, 3'd3, 3'd2, 3'd3, 3'd4};
  localparam logic [14:0] S1  = {3'd4, 3'd3, 3'd2, 3'd1, 3'd2};
  localparam logic [14:0] E1  = {3'd2, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [14:0] E0  = {3'd0, 3'd1, 3'd2, 3'd1, 3'd0};
  localparam logic [14:0] B2A = {3'd2, 3'd3, 3'd2, 3'd3, 3'd4};
  localparam logic [14:0] B2B = {3'd0, 3'd1, 3'd2, 3'd1, 3'd2};

  // [38:31] requirement number, [30] win_start, [29] line_adv,
  // [28] start enable, [27] end enable, [26:15] last line, [14:0] expected
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {8'd4,  4'b1011, 12'd5, S0},   // R4 first line
    {8'd5,  4'b0111, 12'd5, S1},   // R5 second line
    {8'd9,  4'b0111, 12'd5, ID},   // R9 middle
    {8'd9,  4'b0111, 12'd5, ID},   // R9 middle
    {8'd7,  4'b0111, 12'd5, E1},   // R7 second to last
    {8'd6,  4'b0111, 12'd5, E0},   // R6 last
    {8'd9,  4'b0111, 12'd5, ID},   // R9 beyond end
    {8'd8,  4'b1000, 12'd5, ID},   // R8 enables low at start
    {8'd8,  4'b0100, 12'd5, ID},   // R8 enables low
    {8'd2,  4'b1110, 12'd5, S0},   // R2 clear beats advance
    {8'd10, 4'b0010, 12'd5, S0},   // R10 hold without advance
    {8'd11, 4'b1011, 12'd1, B2A},  // R11 two-line window, first
    {8'd11, 4'b0111, 12'd1, B2B},  // R11 two-line window, second
    {8'd6,  4'b1001, 12'd0, E0},   // R6 one-line window, end only
    {8'd9,  4'b0101, 12'd0, ID}    // R9 past a one-line window
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             win_start = 1'b0;
  logic             line_adv = 1'b0;
  logic             start_mirror_en = 1'b0;
  logic             end_mirror_en = 1'b0;
  logic [CNT_W-1:0] last_line = '0;
  logic [14:0]      tap_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mirror_edge_ctrl uut (
    .clk             (clk),
    .rst             (rst),
    .win_start       (win_start),
    .line_adv        (line_adv),
    .start_mirror_en (start_mirror_en),
    .end_mirror_en   (end_mirror_en),
    .last_line       (last_line),
    .tap_sel         (tap_sel)
  );

  task automatic apply(input logic [3:0] ctl, input logic [CNT_W-1:0] last);
    {win_start, line_adv, start_mirror_en, end_mirror_en} = ctl;
    last_line = last;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [14:0] exp);
    checks++;
    if (tap_sel !== exp) begin
      errors++;
      $display("FAIL %s: tap_sel=%h expected %h", req, tap_sel, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", ID);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:27], VEC[i][26:15]);
      tag = $sformatf("R%0d vector %0d", VEC[i][38:31], i);
      check(tag, VEC[i][14:0]);
    end

    // R10: output does not move before the edge that samples the inputs
    apply(4'b1000, 12'd5);
    check("R10 settle", ID);
    {win_start, line_adv, start_mirror_en, end_mirror_en} = 4'b1010;
    #2;
    check("R10 before edge", ID);
    @(posedge clk);
    #1;
    check("R10 after edge", S0);

    // R3: count to the all-ones limit and saturate there
    apply(4'b1001, 12'd4095);
    check("R3 window start far end", ID);
    for (int i = 0; i < 4094; i++) apply(4'b0101, 12'd4095);
    check("R3 R7 at limit minus one", E1);
    apply(4'b0101, 12'd4095);
    check("R3 R6 at limit", E0);
    apply(4'b0101, 12'd4095);
    check("R3 saturate", E0);
    apply(4'b0101, 12'd4095);
    check("R3 saturate again", E0);

    // R1: reset mid-window clears the position
    apply(4'b1010, 12'd5);
    apply(4'b0110, 12'd5);
    check("R5 before reset", S1);
    rst = 1'b1;
    apply(4'b0010, 12'd5);
    check("R1 reset mid-window", ID);
    rst = 1'b0;
    apply(4'b0010, 12'd5);
    check("R1 position cleared by reset", S0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule